// File: doc/BRIEF.md
# Trap Entry State Sequencer

This block performs the bookkeeping a register-window processor needs when it takes a trap into privileged mode. The core presents a trap request together with a 9-bit trap code and a snapshot of its architectural state. That snapshot holds the trap depth, global register level, condition codes, address space identifier, processor state word, hypervisor state word, window pointer, free-window count, and the current and next program counters. One cycle later the block returns the updated depth, global level, processor state word and window pointer. In the same step it records the pre-trap context in a per-depth trap stack.

Each trap-stack entry holds five things: a packed saved-state word, the saved program counter, the saved next program counter, the saved hypervisor state word and the trap code. A read port returns any entry by depth. Reset is treated as power-on reset. It places the depth and the global level at their ceilings and puts the state words into their start-up values. A trap that arrives when the depth is already at its ceiling is refused. The refusal raises an error pulse and changes nothing.

Top module: `trap_entry_seq`

## Requirements
- R1: An accepted request (`cur_tl` < MAX_TL) produces a one-cycle `done` pulse in the cycle after the request. In that same cycle `tl_o` equals `cur_tl`+1.
- R2: The saved-state word is written at the entry indexed by the new depth. It packs the CWP into bits 4:0, the processor state into bits 20:8, the ASI into bits 31:24, the condition codes into bits 39:32 and GL into bits 42:40. Every other bit is zero.
- R3: The same entry stores the trap code, PC, NPC and the presented HPSTATE. All of them are readable through `rd_lvl`.
- R4: `gl_o` becomes `cur_gl`+1, saturating at MAX_GL.
- R5: `pstate_o` is the presented state word with the following changes: bit 4 set, bit 3 cleared, bit 2 set, bit 1 cleared, and bit 9 taking the value of bit 8. All other bits pass through.
- R6: Trap code 0x024 advances the window pointer by one, modulo NWIN.
- R7: Trap codes 0x080 to 0x0BF move the window pointer forward by `cur_cansave`+2, modulo NWIN.
- R8: Trap codes 0x0C0 to 0x0FF move the window pointer back by one, modulo NWIN. Every other code, including 0x023, 0x025 and 0x100, returns `cur_cwp` unchanged.
- R9: After reset the outputs take these values: `tl_o`=MAX_TL, `gl_o`=MAX_GL, `pstate_o`=0x010 (only bit 4 set), `hpstate_o`=0x024 (bits 5 and 2 set), `cwp_o`=0, and `done`/`err` low. Every trap-stack entry reads as zero.
- R10: A request made with `cur_tl` >= MAX_TL gives an `err` pulse in the next cycle with `done` low. It leaves all outputs and all trap-stack entries unchanged.
- R11: After an accepted trap, `hpstate_o` equals the presented `cur_hpstate` unchanged.
- R12: A `rd_lvl` of 0, or a value above MAX_TL, reads all-zero trap-stack outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| trap_req | input | 1 | Trap request, one cycle per trap |
| trap_type | input | 9 | Trap code |
| cur_tl | input | TLW | Current trap depth |
| cur_gl | input | GLW | Current global level |
| cur_ccr | input | 8 | Condition codes |
| cur_asi | input | 8 | Address space identifier |
| cur_pstate | input | 13 | Processor state word |
| cur_hpstate | input | 12 | Hypervisor state word |
| cur_cwp | input | CWPW | Current window pointer |
| cur_cansave | input | CWPW | Free-window count |
| cur_pc | input | PC_W | Program counter |
| cur_npc | input | PC_W | Next program counter |
| rd_lvl | input | TLW | Trap-stack read depth |
| done | output | 1 | Accepted-trap pulse |
| err | output | 1 | Refused-trap pulse |
| tl_o | output | TLW | Updated trap depth |
| gl_o | output | GLW | Updated global level |
| pstate_o | output | 13 | Updated processor state |
| hpstate_o | output | 12 | Hypervisor state |
| cwp_o | output | CWPW | Updated window pointer |
| rd_tstate | output | 64 | Saved-state word at `rd_lvl` |
| rd_tpc | output | PC_W | Saved PC at `rd_lvl` |
| rd_tnpc | output | PC_W | Saved NPC at `rd_lvl` |
| rd_htstate | output | 12 | Saved HPSTATE at `rd_lvl` |
| rd_tt | output | 9 | Saved trap code at `rd_lvl` |

## Verification
All state updates (`done`, `err`, `tl_o`, `gl_o`, `pstate_o`, `hpstate_o`, `cwp_o`) are due at the first rising edge after the request is sampled. The trap-stack entry is written at that same edge, and the read port is combinational from `rd_lvl`, so a saved value can be seen in the very next cycle. The bench drives inputs shortly after the rising edge and advances its reference model on each rising edge. It compares every output on the falling edge, which places each check exactly one register stage after its stimulus. `rd_lvl` walks through every depth, including the out-of-range ones.

// File: rtl/trap_seq_pkg.sv
`timescale 1ns/1ps
package trap_seq_pkg;

  localparam int TT_W  = 9;
  localparam int PS_W  = 13;
  localparam int HPS_W = 12;
  localparam int TS_W  = 64;

  typedef enum logic [1:0] {
    TK_PLAIN = 2'd0,
    TK_CLEAN = 2'd1,
    TK_SPILL = 2'd2,
    TK_FILL  = 2'd3
  } trap_kind_e;

  localparam logic [PS_W-1:0]  PS_POR  = 13'h0010;
  localparam logic [HPS_W-1:0] HPS_POR = 12'h024;

  // Processor-state rewrite on privileged entry: force masks then copy tle into cle.
  function automatic logic [PS_W-1:0] entry_pstate(input logic [PS_W-1:0] ps);
    logic [PS_W-1:0] set_m, clr_m, r;
    set_m = 13'h0014;          // pef, priv
    clr_m = 13'h020A;          // am, ie, and cle (refilled below)
    r     = (ps & ~clr_m) | set_m;
    r     = r | (ps[8] ? 13'h0200 : 13'h0000);
    return r;
  endfunction

  // Packs the saved-state word.
  function automatic logic [TS_W-1:0] pack_tstate(
    input logic [2:0]      gl,
    input logic [7:0]      ccr,
    input logic [7:0]      asi,
    input logic [PS_W-1:0] ps,
    input logic [4:0]      cwp
  );
    logic [TS_W-1:0] w;
    w = '0;
    w[42:40] = gl;
    w[39:32] = ccr;
    w[31:24] = asi;
    w[20:8]  = ps;
    w[4:0]   = cwp;
    return w;
  endfunction

endpackage

// File: rtl/trap_classify.sv
`timescale 1ns/1ps
module trap_classify
  import trap_seq_pkg::*;
(
  input  logic [TT_W-1:0] tt,
  output trap_kind_e      kind
);
  logic hi_zero;
  assign hi_zero = (tt[8] == 1'b0);

  always_comb begin
    kind = TK_PLAIN;
    if (tt == 9'h024)                          kind = TK_CLEAN;
    else if (hi_zero && tt[7:6] == 2'b10)      kind = TK_SPILL;
    else if (hi_zero && tt[7:6] == 2'b11)      kind = TK_FILL;
  end
endmodule

// File: rtl/trap_cwp_adj.sv
`timescale 1ns/1ps
module trap_cwp_adj
  import trap_seq_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CWPW = (NWIN > 1) ? $clog2(NWIN) : 1
)(
  input  trap_kind_e      kind,
  input  logic [CWPW-1:0] cwp,
  input  logic [CWPW-1:0] cansave,
  output logic [CWPW-1:0] cwp_nxt
);
  localparam int SW = CWPW + 2;
  localparam logic [CWPW-1:0] TOP = CWPW'(NWIN - 1);

  logic [SW-1:0]   spill_sum;
  logic [CWPW-1:0] spill_w, clean_w, fill_w;

  assign spill_sum = SW'(cwp) + SW'(cansave) + SW'(2);
  assign spill_w   = CWPW'(spill_sum % SW'(NWIN));
  assign clean_w   = (cwp == TOP) ? '0 : cwp + CWPW'(1);
  assign fill_w    = (cwp == '0) ? TOP : cwp - CWPW'(1);

  always_comb begin
    unique case (kind)
      TK_CLEAN: cwp_nxt = clean_w;
      TK_SPILL: cwp_nxt = spill_w;
      TK_FILL:  cwp_nxt = fill_w;
      default:  cwp_nxt = cwp;
    endcase
  end
endmodule

// File: rtl/trap_stack.sv
`timescale 1ns/1ps
module trap_stack
  import trap_seq_pkg::*;
#(
  parameter int MAX_TL = 6,
  parameter int PC_W   = 64,
  localparam int TLW   = $clog2(MAX_TL + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [TLW-1:0]    wlvl,
  input  logic [TS_W-1:0]   w_tstate,
  input  logic [PC_W-1:0]   w_tpc,
  input  logic [PC_W-1:0]   w_tnpc,
  input  logic [HPS_W-1:0]  w_htstate,
  input  logic [TT_W-1:0]   w_tt,
  input  logic [TLW-1:0]    rlvl,
  output logic [TS_W-1:0]   r_tstate,
  output logic [PC_W-1:0]   r_tpc,
  output logic [PC_W-1:0]   r_tnpc,
  output logic [HPS_W-1:0]  r_htstate,
  output logic [TT_W-1:0]   r_tt
);
  logic [TS_W-1:0]  ts_q  [1:MAX_TL];
  logic [PC_W-1:0]  pc_q  [1:MAX_TL];
  logic [PC_W-1:0]  npc_q [1:MAX_TL];
  logic [HPS_W-1:0] hts_q [1:MAX_TL];
  logic [TT_W-1:0]  tt_q  [1:MAX_TL];

  logic [MAX_TL:1] wr_hit;
  logic [MAX_TL:1] rd_hit;

  for (genvar g = 1; g <= MAX_TL; g++) begin : g_lvl
    assign wr_hit[g] = we && (wlvl == TLW'(g));
    assign rd_hit[g] = (rlvl == TLW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i <= MAX_TL; i++) begin
        ts_q[i]  <= '0;
        pc_q[i]  <= '0;
        npc_q[i] <= '0;
        hts_q[i] <= '0;
        tt_q[i]  <= '0;
      end
    end else begin
      for (int i = 1; i <= MAX_TL; i++) begin
        if (wr_hit[i]) begin
          ts_q[i]  <= w_tstate;
          pc_q[i]  <= w_tpc;
          npc_q[i] <= w_tnpc;
          hts_q[i] <= w_htstate;
          tt_q[i]  <= w_tt;
        end
      end
    end
  end

  always_comb begin
    r_tstate  = '0;
    r_tpc     = '0;
    r_tnpc    = '0;
    r_htstate = '0;
    r_tt      = '0;
    for (int i = 1; i <= MAX_TL; i++) begin
      if (rd_hit[i]) begin
        r_tstate  = ts_q[i];
        r_tpc     = pc_q[i];
        r_tnpc    = npc_q[i];
        r_htstate = hts_q[i];
        r_tt      = tt_q[i];
      end
    end
  end

  AST_WRITE_ONE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit)) else $error("write hits more than one level"); // R2
  AST_WRITE_LEVEL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (wlvl >= TLW'(1)) && (wlvl <= TLW'(MAX_TL))) else $error("write level out of range"); // R1
endmodule

// File: rtl/trap_entry_seq.sv
`timescale 1ns/1ps
module trap_entry_seq
  import trap_seq_pkg::*;
#(
  parameter int MAX_TL = 6,
  parameter int MAX_GL = 3,
  parameter int NWIN   = 8,
  parameter int PC_W   = 64,
  localparam int TLW   = $clog2(MAX_TL + 1),
  localparam int GLW   = $clog2(MAX_GL + 1),
  localparam int CWPW  = (NWIN > 1) ? $clog2(NWIN) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_req,
  input  logic [8:0]        trap_type,
  input  logic [TLW-1:0]    cur_tl,
  input  logic [GLW-1:0]    cur_gl,
  input  logic [7:0]        cur_ccr,
  input  logic [7:0]        cur_asi,
  input  logic [12:0]       cur_pstate,
  input  logic [11:0]       cur_hpstate,
  input  logic [CWPW-1:0]   cur_cwp,
  input  logic [CWPW-1:0]   cur_cansave,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [PC_W-1:0]   cur_npc,
  input  logic [TLW-1:0]    rd_lvl,
  output logic              done,
  output logic              err,
  output logic [TLW-1:0]    tl_o,
  output logic [GLW-1:0]    gl_o,
  output logic [12:0]       pstate_o,
  output logic [11:0]       hpstate_o,
  output logic [CWPW-1:0]   cwp_o,
  output logic [63:0]       rd_tstate,
  output logic [PC_W-1:0]   rd_tpc,
  output logic [PC_W-1:0]   rd_tnpc,
  output logic [11:0]       rd_htstate,
  output logic [8:0]        rd_tt
);
  localparam logic [TLW-1:0] TL_TOP = TLW'(MAX_TL);
  localparam logic [GLW-1:0] GL_TOP = GLW'(MAX_GL);

  function automatic logic [GLW-1:0] next_gl(input logic [GLW-1:0] g);
    return (g >= GL_TOP) ? GL_TOP : g + GLW'(1);
  endfunction

  // Named internal events
  logic            accept_w, refuse_w;
  logic [TLW-1:0]  new_tl_w;
  trap_kind_e      kind_w;
  logic [CWPW-1:0] cwp_nxt_w;
  logic [TS_W-1:0] tstate_w;

  assign accept_w = trap_req && (cur_tl < TL_TOP);
  assign refuse_w = trap_req && !accept_w;
  assign new_tl_w = cur_tl + TLW'(1);
  assign tstate_w = pack_tstate(3'(cur_gl), cur_ccr, cur_asi, cur_pstate, 5'(cur_cwp));

  trap_classify u_cls (
    .tt   (trap_type),
    .kind (kind_w)
  );

  trap_cwp_adj #(.NWIN(NWIN)) u_cwp (
    .kind    (kind_w),
    .cwp     (cur_cwp),
    .cansave (cur_cansave),
    .cwp_nxt (cwp_nxt_w)
  );

  trap_stack #(.MAX_TL(MAX_TL), .PC_W(PC_W)) u_stk (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (accept_w),
    .wlvl      (new_tl_w),
    .w_tstate  (tstate_w),
    .w_tpc     (cur_pc),
    .w_tnpc    (cur_npc),
    .w_htstate (cur_hpstate),
    .w_tt      (trap_type),
    .rlvl      (rd_lvl),
    .r_tstate  (rd_tstate),
    .r_tpc     (rd_tpc),
    .r_tnpc    (rd_tnpc),
    .r_htstate (rd_htstate),
    .r_tt      (rd_tt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      err       <= 1'b0;
      tl_o      <= TL_TOP;
      gl_o      <= GL_TOP;
      pstate_o  <= PS_POR;
      hpstate_o <= HPS_POR;
      cwp_o     <= '0;
    end else begin
      done <= accept_w;
      err  <= refuse_w;
      if (accept_w) begin
        tl_o      <= new_tl_w;
        gl_o      <= next_gl(cur_gl);
        pstate_o  <= entry_pstate(cur_pstate);
        hpstate_o <= cur_hpstate;
        cwp_o     <= cwp_nxt_w;
      end
    end
  end

  AST_DONE_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && cur_tl < TL_TOP) |=> (done && !err)) else $error("done missing"); // R1
  AST_TL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tl_o == $past(cur_tl) + TLW'(1))) else $error("depth step wrong"); // R1
  AST_GL_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (gl_o <= GL_TOP) && (($past(cur_gl) < GL_TOP) ? (gl_o > $past(cur_gl)) : (gl_o == GL_TOP))) else $error("gl wrong"); // R4
  AST_PSTATE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pstate_o[4] && !pstate_o[3] && pstate_o[2] && !pstate_o[1] && (pstate_o[9] == $past(cur_pstate[8])))) else $error("pstate bits wrong"); // R5
  AST_CLEAN_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(trap_type) == 9'h024) |-> (cwp_o != $past(cur_cwp))) else $error("clean did not move"); // R6
  AST_PLAIN_KEEPS_CWP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(trap_type[8] || trap_type[7:6] == 2'b00) && $past(trap_type) != 9'h024) |-> (cwp_o == $past(cur_cwp))) else $error("cwp moved"); // R8
  AST_REFUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && cur_tl >= TL_TOP) |=> (err && !done && $stable(tl_o) && $stable(gl_o) && $stable(pstate_o) && $stable(cwp_o))) else $error("refusal changed state"); // R10
  AST_HPSTATE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (hpstate_o == $past(cur_hpstate))) else $error("hpstate altered"); // R11
endmodule

// File: tb/tb_trap_entry_seq.sv
`timescale 1ns/1ps
module tb_trap_entry_seq;
  localparam int MAX_TL = 6;
  localparam int MAX_GL = 3;
  localparam int NWIN   = 8;
  localparam int PC_W   = 64;
  localparam int TLW    = 3;
  localparam int GLW    = 2;
  localparam int CWPW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_req = 1'b0;
  logic [8:0] trap_type = '0;
  logic [TLW-1:0] cur_tl = '0;
  logic [GLW-1:0] cur_gl = '0;
  logic [7:0] cur_ccr = '0, cur_asi = '0;
  logic [12:0] cur_pstate = '0;
  logic [11:0] cur_hpstate = '0;
  logic [CWPW-1:0] cur_cwp = '0, cur_cansave = '0;
  logic [PC_W-1:0] cur_pc = '0, cur_npc = '0;
  logic [TLW-1:0] rd_lvl = '0;
  logic done, err;
  logic [TLW-1:0] tl_o;
  logic [GLW-1:0] gl_o;
  logic [12:0] pstate_o;
  logic [11:0] hpstate_o;
  logic [CWPW-1:0] cwp_o;
  logic [63:0] rd_tstate;
  logic [PC_W-1:0] rd_tpc, rd_tnpc;
  logic [11:0] rd_htstate;
  logic [8:0] rd_tt;

  always #10 clk = ~clk;

  trap_entry_seq #(.MAX_TL(MAX_TL), .MAX_GL(MAX_GL), .NWIN(NWIN), .PC_W(PC_W)) dut (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
    .cur_tl(cur_tl), .cur_gl(cur_gl), .cur_ccr(cur_ccr), .cur_asi(cur_asi),
    .cur_pstate(cur_pstate), .cur_hpstate(cur_hpstate), .cur_cwp(cur_cwp),
    .cur_cansave(cur_cansave), .cur_pc(cur_pc), .cur_npc(cur_npc), .rd_lvl(rd_lvl),
    .done(done), .err(err), .tl_o(tl_o), .gl_o(gl_o), .pstate_o(pstate_o),
    .hpstate_o(hpstate_o), .cwp_o(cwp_o), .rd_tstate(rd_tstate), .rd_tpc(rd_tpc),
    .rd_tnpc(rd_tnpc), .rd_htstate(rd_htstate), .rd_tt(rd_tt)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // Reference model state
  int m_tl, m_gl, m_cwp;
  bit m_done, m_err;
  logic [12:0] m_ps;
  logic [11:0] m_hp;
  logic [63:0] m_ts [0:MAX_TL];
  logic [63:0] m_pc [0:MAX_TL];
  logic [63:0] m_npc [0:MAX_TL];
  logic [11:0] m_hts [0:MAX_TL];
  logic [8:0]  m_tt [0:MAX_TL];
  string cwp_tag = "R8";

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_por();
    m_tl = MAX_TL; m_gl = MAX_GL; m_cwp = 0;
    m_ps = 13'h0010; m_hp = 12'h024; m_done = 0; m_err = 0;
    for (int i = 0; i <= MAX_TL; i++) begin
      m_ts[i] = '0; m_pc[i] = '0; m_npc[i] = '0; m_hts[i] = '0; m_tt[i] = '0;
    end
  endtask

  initial model_por();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_por();
    else begin
      m_done = 0; m_err = 0;
      if (trap_req) begin
        if (int'(cur_tl) >= MAX_TL) m_err = 1;
        else begin
          int lv, t, w;
          lv = int'(cur_tl) + 1;
          m_ts[lv] = (64'(cur_gl) << 40) + (64'(cur_ccr) << 32) + (64'(cur_asi) << 24)
                   + (64'(cur_pstate) << 8) + 64'(cur_cwp);
          m_pc[lv] = cur_pc; m_npc[lv] = cur_npc;
          m_hts[lv] = cur_hpstate; m_tt[lv] = trap_type;
          m_tl = lv;
          m_gl = (int'(cur_gl) + 1 > MAX_GL) ? MAX_GL : int'(cur_gl) + 1;
          m_ps = cur_pstate;
          m_ps[4] = 1'b1; m_ps[3] = 1'b0; m_ps[2] = 1'b1; m_ps[1] = 1'b0;
          m_ps[9] = cur_pstate[8];
          m_hp = cur_hpstate;
          t = int'(trap_type);
          w = int'(cur_cwp);
          if (t == 36) begin w = w + 1; cwp_tag = "R6"; end
          else if (t >= 128 && t < 192) begin w = w + int'(cur_cansave) + 2; cwp_tag = "R7"; end
          else if (t >= 192 && t < 256) begin w = w - 1; cwp_tag = "R8"; end
          else cwp_tag = "R8";
          m_cwp = ((w % NWIN) + NWIN) % NWIN;
          m_done = 1;
        end
      end
    end
  end

  // Read depth walks every value including out-of-range ones
  always @(posedge clk) begin
    #3 rd_lvl <= (rd_lvl == TLW'(MAX_TL + 1)) ? '0 : rd_lvl + 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int lv;
      chk("R1", "done", 64'(done), 64'(m_done));
      chk("R10", "err", 64'(err), 64'(m_err));
      chk("R1", "tl_o", 64'(tl_o), 64'(m_tl));
      chk("R4", "gl_o", 64'(gl_o), 64'(m_gl));
      chk("R5", "pstate_o", 64'(pstate_o), 64'(m_ps));
      chk("R11", "hpstate_o", 64'(hpstate_o), 64'(m_hp));
      chk(cwp_tag, "cwp_o", 64'(cwp_o), 64'(m_cwp));
      lv = int'(rd_lvl);
      if (lv >= 1 && lv <= MAX_TL) begin
        chk("R2", "rd_tstate", rd_tstate, m_ts[lv]);
        chk("R3", "rd_tpc", rd_tpc, m_pc[lv]);
        chk("R3", "rd_tnpc", rd_tnpc, m_npc[lv]);
        chk("R3", "rd_htstate", 64'(rd_htstate), 64'(m_hts[lv]));
        chk("R3", "rd_tt", 64'(rd_tt), 64'(m_tt[lv]));
      end else begin
        chk("R12", "rd_zero", rd_tstate | rd_tpc | rd_tnpc | 64'(rd_htstate) | 64'(rd_tt), 64'd0);
      end
    end
  end

  task automatic trap(input logic [8:0] tt, input int tl, input int gl, input int cwp,
                      input int cs, input logic [12:0] ps);
    @(posedge clk); #2;
    trap_req = 1'b1; trap_type = tt; cur_tl = TLW'(tl); cur_gl = GLW'(gl);
    cur_cwp = CWPW'(cwp); cur_cansave = CWPW'(cs); cur_pstate = ps;
    cur_ccr = 8'($urandom); cur_asi = 8'($urandom); cur_hpstate = 12'($urandom);
    cur_pc = {32'($urandom), 32'($urandom)}; cur_npc = cur_pc + 64'd4;
    @(posedge clk); #2;
    trap_req = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL R1 watchdog expired: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R9: power-on values
    chk("R9", "por tl", 64'(tl_o), 64'(MAX_TL));
    chk("R9", "por gl", 64'(gl_o), 64'(MAX_GL));
    chk("R9", "por pstate", 64'(pstate_o), 64'h010);
    chk("R9", "por hpstate", 64'(hpstate_o), 64'h024);
    chk("R9", "por cwp/done/err", {cwp_o, done, err}, 64'd0);
    // R6 wrap, R7 wrap, R8 wrap and passthrough
    trap(9'h024, 0, 0, 7, 0, 13'h0100);
    trap(9'h024, 1, 1, 2, 0, 13'h1FFF);
    trap(9'h080, 2, 2, 6, 3, 13'h0000);
    trap(9'h0BF, 3, 3, 7, 7, 13'h0ABC);
    trap(9'h0C0, 4, 3, 0, 1, 13'h1EFF);
    trap(9'h0FF, 5, 2, 5, 1, 13'h0155);
    trap(9'h023, 0, 0, 4, 4, 13'h0008);
    trap(9'h025, 1, 0, 4, 4, 13'h0002);
    trap(9'h100, 2, 0, 1, 4, 13'h0200);
    trap(9'h07F, 3, 0, 3, 4, 13'h0300);
    // R10 refusal at and above ceiling
    trap(9'h024, MAX_TL, 0, 3, 0, 13'h0000);
    trap(9'h0C0, 7, 1, 3, 0, 13'h0000);
    repeat (3) @(posedge clk);
    // R4 saturation repeatedly, mixed random traffic
    for (int k = 0; k < 300; k++) begin
      trap(9'($urandom), int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
           int'($urandom_range(0, 7)), int'($urandom_range(0, 7)), 13'($urandom));
      if ($urandom_range(0, 3) == 0) @(posedge clk);
    end
    for (int k = 0; k < 60; k++)
      trap(9'h080 + 9'($urandom_range(0, 127)), int'($urandom_range(0, 5)),
           int'($urandom_range(0, 3)), int'($urandom_range(0, 7)), int'($urandom_range(0, 7)), 13'($urandom));
    repeat (20) @(posedge clk);
    @(negedge clk); #1;
    finish_run();
  end
endmodule